// File: doc/BRIEF.md
# Radix-8 Booth Multiplier Modulo 2^n-1

This block multiplies two n-bit residues in the 2^n-1 channel of a three-modulus residue number system and returns their product reduced modulo 2^n-1. The multiplier operand B is zero-extended and then recoded into signed radix-8 digits in the range -4..+4. Each digit is taken from a 4-bit window, and successive windows step by three bits and overlap by one. The multiples A, 2A and 4A are free rotations of A. The hard multiple 3A is made ahead of digit selection by a parallel-prefix adder with end-around carry.

Each digit picks one multiple. The block inverts it bitwise when the digit is negative and rotates it left by three bit positions per digit rank, which is the digit weight because 2^n is congruent to 1. This gives floor(n/3)+1 partial products. A carry-save array whose carries wrap from the top bit to bit 0 compresses them, and a second end-around-carry prefix adder resolves the result. An all-ones sum stands for zero and is mapped to zero. One output register with a synchronous reset holds the result.

Either operand may be any n-bit value. The all-ones pattern is taken as another spelling of zero.

Top module: `mersenne_mul`

## Requirements
- R1: `p_o` equals (`a_i` × `b_i`) mod (2^N-1) at the first rising edge after the operands are presented, for every pair of N-bit operand values, including all-ones operands.
- R2: `p_o` never shows the all-ones pattern; its value always lies in 0..2^N-2.
- R3: When either operand is 0, `p_o` is 0 after the next edge.
- R4: While `rst` is high at a rising edge, `p_o` becomes 0 at that edge, whatever the operands are.
- R5: When `a_i` is 1, `p_o` equals `b_i` after the next edge, except that an all-ones `b_i` gives 0.
- R6: When `a_i` is 2^N-2 (minus one in the ring), `p_o` equals the bitwise inverse of `b_i` after the next edge, with an all-ones inverse given as 0.
- R7: When `b_i` is 8, `p_o` equals `a_i` rotated left by three bit positions after the next edge, with an all-ones result given as 0.
- R8: The same product rule as R1 holds when N is 16 and when N is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the product register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the product register |
| a_i | input | N | Multiplicand residue |
| b_i | input | N | Multiplier residue; this operand is Booth-recoded |
| p_o | output | N | Registered product modulo 2^N-1 |

## Verification
The datapath has no internal state, so every result is due at the first rising edge after its operands are applied. The bench changes the operands on a falling edge and reads `p_o` on the following falling edge. Each check therefore looks at exactly one register load, and no edge ordering can affect it. The reset value is read on the falling edge after a reset edge, while nonzero operands are held at the inputs.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        MAG_0 = 3'd0,
        MAG_1 = 3'd1,
        MAG_2 = 3'd2,
        MAG_3 = 3'd3,
        MAG_4 = 3'd4
    } mag_e;

    typedef struct packed {
        logic neg;
        mag_e mag;
    } digit_t;

    // number of radix-8 digits for an n-bit zero-extended multiplier
    function automatic int digit_count(input int n);
        return n / 3 + 1;
    endfunction

    // window bits {b[3i+2], b[3i+1], b[3i], b[3i-1]} -> signed digit
    function automatic digit_t decode_window(input logic [3:0] w);
        int     v;
        int     m;
        digit_t d;
        v = (w[3] ? -4 : 0) + (w[2] ? 2 : 0) + (w[1] ? 1 : 0) + (w[0] ? 1 : 0);
        m = (v < 0) ? -v : v;
        d.neg = (v < 0);
        case (m)
            1:       d.mag = MAG_1;
            2:       d.mag = MAG_2;
            3:       d.mag = MAG_3;
            4:       d.mag = MAG_4;
            default: d.mag = MAG_0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mm_prefix_eac.sv
module mm_prefix_eac #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] s
);
    localparam int L = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] g [L+1];
    logic [N-1:0] p [L+1];
    logic [N-1:0] cin;
    logic         wrap;

    assign g[0] = x & y;
    assign p[0] = x ^ y;

    for (genvar lv = 1; lv <= L; lv++) begin : g_lvl
        localparam int D = 1 << (lv - 1);
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i >= D) begin : g_merge
                assign g[lv][i] = g[lv-1][i] | (p[lv-1][i] & g[lv-1][i-D]);
                assign p[lv][i] = p[lv-1][i] & p[lv-1][i-D];
            end else begin : g_pass
                assign g[lv][i] = g[lv-1][i];
                assign p[lv][i] = p[lv-1][i];
            end
        end
    end

    // the carry out of the top bit re-enters at bit 0
    assign wrap   = g[L][N-1];
    assign cin[0] = wrap;
    for (genvar i = 1; i < N; i++) begin : g_cin
        assign cin[i] = g[L][i-1] | (p[L][i-1] & wrap);
    end

    assign s = p[0] ^ cin;
endmodule

// File: rtl/mm_booth_sel.sv
module mm_booth_sel #(
    parameter int N   = 8,
    parameter int ROT = 0
) (
    input  logic [3:0]   win,
    input  logic [N-1:0] m1,
    input  logic [N-1:0] m2,
    input  logic [N-1:0] m3,
    input  logic [N-1:0] m4,
    output logic [N-1:0] pp
);
    import mm_pkg::*;

    digit_t         dig;
    logic [N-1:0]   pick;
    logic [N-1:0]   signed_pick;
    logic [2*N-1:0] dbl;

    always_comb begin
        dig = decode_window(win);
        case (dig.mag)
            MAG_1:   pick = m1;
            MAG_2:   pick = m2;
            MAG_3:   pick = m3;
            MAG_4:   pick = m4;
            default: pick = '0;
        endcase
        // one's complement is the negative modulo 2^N-1
        signed_pick = dig.neg ? ~pick : pick;
        dbl = {signed_pick, signed_pick};
    end

    // rotate left by ROT: weight 8^i folded modulo 2^N-1
    assign pp = dbl[2*N-1-ROT -: N];
endmodule

// File: rtl/mm_csa_ring.sv
module mm_csa_ring #(
    parameter int N = 8,
    parameter int K = 3
) (
    input  logic [N-1:0] pp [K],
    output logic [N-1:0] sum_o,
    output logic [N-1:0] car_o
);
    logic [N-1:0] ss [1:K-1];
    logic [N-1:0] cc [1:K-1];

    assign ss[1] = pp[0];
    assign cc[1] = pp[1];

    for (genvar i = 2; i < K; i++) begin : g_row
        logic [N-1:0] maj;
        assign ss[i] = ss[i-1] ^ cc[i-1] ^ pp[i];
        assign maj   = (ss[i-1] & cc[i-1]) | (ss[i-1] & pp[i]) | (cc[i-1] & pp[i]);
        // carry from bit N-1 wraps around to bit 0
        assign cc[i] = {maj[N-2:0], maj[N-1]};
    end

    assign sum_o = ss[K-1];
    assign car_o = cc[K-1];
endmodule

// File: rtl/mersenne_mul.sv
module mersenne_mul #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] p_o
);
    localparam int K  = mm_pkg::digit_count(N);
    localparam int WX = 3 * K + 1;
    localparam int PAD = WX - N - 1;

    logic [WX-1:0] bx;
    logic [N-1:0]  m1, m2, m3, m4;
    logic [N-1:0]  pp [K];
    logic [N-1:0]  red_s, red_c, raw;
    logic [N-1:0]  norm;

    // zero extension keeps the top window non-negative
    assign bx = {{PAD{1'b0}}, b_i, 1'b0};

    assign m1 = a_i;
    assign m2 = {a_i[N-2:0], a_i[N-1]};
    assign m4 = {a_i[N-3:0], a_i[N-1:N-2]};

    mm_prefix_eac #(.N(N)) u_hard3 (
        .x (m1),
        .y (m2),
        .s (m3)
    );

    for (genvar i = 0; i < K; i++) begin : g_dig
        mm_booth_sel #(.N(N), .ROT((3 * i) % N)) u_sel (
            .win (bx[3*i +: 4]),
            .m1  (m1),
            .m2  (m2),
            .m3  (m3),
            .m4  (m4),
            .pp  (pp[i])
        );
    end

    mm_csa_ring #(.N(N), .K(K)) u_csa (
        .pp    (pp),
        .sum_o (red_s),
        .car_o (red_c)
    );

    mm_prefix_eac #(.N(N)) u_final (
        .x (red_s),
        .y (red_c),
        .s (raw)
    );

    assign norm = (&raw) ? '0 : raw;

    always_ff @(posedge clk) begin
        if (rst) p_o <= '0;
        else     p_o <= norm;
    end
endmodule

// File: rtl/mm_mul_checker.sv
module mm_mul_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] p_o
);
    localparam logic [N-1:0] ONES  = '1;
    localparam logic [N-1:0] MNEG1 = ONES - 1'b1;
    localparam logic [N-1:0] EIGHT = N'(8);

    function automatic logic [N-1:0] fold(input logic [N-1:0] v);
        return (v == ONES) ? '0 : v;
    endfunction

    function automatic logic [N-1:0] rot3(input logic [N-1:0] v);
        logic [2*N-1:0] d;
        d = {v, v};
        return d[2*N-4 -: N];
    endfunction

    a_r2_no_all_ones: assert property (@(posedge clk) disable iff (rst)
        p_o != ONES);

    a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (a_i == '0 || b_i == '0) |=> p_o == '0);

    a_r4_reset: assert property (@(posedge clk)
        rst |=> p_o == '0);

    a_r5_unit: assert property (@(posedge clk) disable iff (rst)
        (a_i == N'(1)) |=> p_o == fold($past(b_i)));

    a_r6_minus_one: assert property (@(posedge clk) disable iff (rst)
        (a_i == MNEG1) |=> p_o == fold(~$past(b_i)));

    a_r7_shift: assert property (@(posedge clk) disable iff (rst)
        (b_i == EIGHT) |=> p_o == fold(rot3($past(a_i))));
endmodule

bind mersenne_mul mm_mul_checker #(.N(N)) u_chk (
    .clk (clk),
    .rst (rst),
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p_o)
);

// File: tb/sim_mersenne_mul.sv
module sim_mersenne_mul;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0]  a0 = '0, b0 = '0;
    logic [15:0] a1 = '0, b1 = '0;
    logic [31:0] a2 = '0, b2 = '0;
    logic [5:0]  p0;
    logic [15:0] p1;
    logic [31:0] p2;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mersenne_mul #(.N(6))  u0 (.clk(clk), .rst(rst), .a_i(a0), .b_i(b0), .p_o(p0));
    mersenne_mul #(.N(16)) u1 (.clk(clk), .rst(rst), .a_i(a1), .b_i(b1), .p_o(p1));
    mersenne_mul #(.N(32)) u2 (.clk(clk), .rst(rst), .a_i(a2), .b_i(b2), .p_o(p2));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] modprod(input logic [63:0] a, input logic [63:0] b,
                                            input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return ((a % m) * (b % m)) % m;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R4: reset clears the register while nonzero operands are held
        a0 = 6'd5; b0 = 6'd7; a1 = 16'd300; b1 = 16'd77; a2 = 32'd12345; b2 = 32'd999;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R4 n6", 64'(p0), 64'd0);
        chk("R4 n16", 64'(p1), 64'd0);
        chk("R4 n32", 64'(p2), 64'd0);
        rst = 1'b0;

        // exhaustive sweep for n=6
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                logic [63:0] e;
                string tag;
                a0 = 6'(a); b0 = 6'(b);
                @(negedge clk);
                e = modprod(64'(a), 64'(b), 6);
                if (a == 0 || b == 0)  tag = "R3";
                else if (a == 1)       tag = "R5";
                else if (a == 62)      tag = "R6";
                else if (b == 8)       tag = "R7";
                else                   tag = "R1";
                chk(tag, 64'(p0), e);
                if (p0 == 6'h3F) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: actual=%0d expected=<63", p0);
                end else begin
                    checks++;
                end
            end
        end

        // R8: random vectors for n=16 and n=32, plus edge operands
        for (int k = 0; k < 600; k++) begin
            if (k == 0) begin
                a1 = '1; b1 = 16'd1234; a2 = '1; b2 = 32'd99;
            end else if (k == 1) begin
                a1 = 16'hFFFE; b1 = 16'hFFFE; a2 = 32'hFFFF_FFFE; b2 = 32'hFFFF_FFFE;
            end else if (k == 2) begin
                a1 = 16'hABCD; b1 = 16'd8; a2 = 32'hDEAD_BEEF; b2 = 32'd8;
            end else begin
                a1 = 16'($urandom); b1 = 16'($urandom);
                a2 = $urandom; b2 = $urandom;
            end
            @(negedge clk);
            chk("R8 n16", 64'(p1), modprod(64'(a1), 64'(b1), 16));
            chk("R8 n32", 64'(p2), modprod(64'(a2), 64'(b2), 32));
        end

        // R4 again: reset mid-run with live operands
        a0 = 6'd9; b0 = 6'd11;
        rst = 1'b1;
        @(negedge clk);
        chk("R4 mid-run", 64'(p0), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 64'(p0), 64'd36);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule